// File: doc/BRIEF.md
# Pulse-Swallow Modulus Control Counter

This block sits behind an external dual-modulus prescaler that divides by P or P+1. It is clocked by the prescaler output, so each of its clocks stands for one prescaler output period. It holds a swallow count A and a main count M. During each cycle of M clocks it drives the modulus-control line low for the first A clocks, which makes the prescaler divide by P+1. It then drives the line high for the remaining M−A clocks, which makes the prescaler divide by P. The overall ratio from the prescaler input to the block's cycle output is therefore M·P + A.

At the last clock of every cycle the block raises a one-clock cycle pulse. This pulse is the divided feedback frequency used by a phase comparator elsewhere. New A and M values are taken in by a single-cycle load strobe. A load does not let the running cycle finish. Both counters are thrown back to the start of a cycle and count from there with the new values, so the time from a channel change to the first feedback pulse is fixed at M clocks. A configuration flag reports a loaded pair that the counter cannot serve correctly.

Top module: `pulse_swallow_ctrl`

## Requirements
- R1: While `rst_n` is low, `mc`, `fv` and `cfg_err` are 0. On the second rising clock edge after `rst_n` rises, the block stands at position 0 of a cycle with the default program A=3, M=16, and counts on from there.
- R2: A cycle lasts M clocks, numbered as positions 0 to M−1. In position k, `mc` is 0 when k < A and 1 when k ≥ A.
- R3: `fv` is 1 exactly in position M−1 for one clock. It therefore repeats every M clocks.
- R4: With A=0, `mc` is 1 in every position of the cycle, including position 0.
- R5: When `load` is 1 at a rising edge, the clock after that edge is position 0 with the new `a_in`/`m_in`. This holds whatever position the old cycle had reached, the terminal position included.
- R6: While `load` is held at 1, every clock is position 0. `fv` stays 0 and `mc` equals (A==0).
- R7: `cfg_err` is set by a load with M < 8 or M ≤ A. It is cleared by a load with a valid pair, and it keeps its value between loads.
- R8: The extreme settings A=127 with M=128, and A=1 with M=1023, follow R2 and R3.
- R9: While `load` is 0, changes on `a_in` and `m_in` have no effect on `mc`, `fv` or `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fin | input | 1 | Prescaler output used as the clock; rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Synchronous strobe that takes a_in/m_in and restarts the cycle |
| a_in | input | 7 | Swallow count A, 0 to 127 |
| m_in | input | 10 | Main count M, 8 to 1023, must exceed A |
| mc | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| fv | output | 1 | One-clock pulse in the last clock of each cycle |
| cfg_err | output | 1 | Last loaded pair was out of range |

## Verification
Suppose the swallow counter holds a wrong value. The edge where `mc` rises then moves by that many clocks within the same cycle. Suppose the main counter holds a wrong value. The spacing of `fv` changes at the very next terminal position, which is at most M clocks away. A failed restart on load shows within one clock: the first sample after the strobe no longer shows position 0. The bench therefore compares `mc` and `fv` on every clock against a position model over two full cycles per program.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
  // Default program applied at reset
  localparam int unsigned DEF_A_VAL = 3;
  localparam int unsigned DEF_M_VAL = 16;
  // Smallest main count the counter supports
  localparam int unsigned M_FLOOR   = 8;

  // A loaded pair is unusable when M is too small or does not exceed A
  function automatic logic pair_bad(input int unsigned m, input int unsigned a,
                                    input int unsigned floor_m);
    return (m < floor_m) || (m <= a);
  endfunction
endpackage

// File: rtl/psc_rst_sync.sv
`timescale 1ns/1ps
module psc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/psc_shadow.sv
`timescale 1ns/1ps
module psc_shadow
  import psc_pkg::*;
#(
  parameter int A_W   = 7,
  parameter int M_W   = 10,
  parameter int M_MIN = M_FLOOR,
  parameter int DEF_A = DEF_A_VAL,
  parameter int DEF_M = DEF_M_VAL
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [M_W-1:0] m_in,
  output logic [A_W-1:0] a_q,
  output logic [M_W-1:0] m_q,
  output logic           err_q
);
  localparam logic [A_W-1:0] A_RST = A_W'(DEF_A);
  localparam logic [M_W-1:0] M_RST = M_W'(DEF_M);

  logic [A_W-1:0] a_d;
  logic [M_W-1:0] m_d;
  logic           err_d;

  always_comb begin
    a_d   = a_q;
    m_d   = m_q;
    err_d = err_q;
    if (load) begin
      a_d   = a_in;
      m_d   = m_in;
      err_d = pair_bad(int'(m_in), int'(a_in), M_MIN);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= A_RST;
      m_q   <= M_RST;
      err_q <= 1'b0;
    end else begin
      a_q   <= a_d;
      m_q   <= m_d;
      err_q <= err_d;
    end
  end

  // R9: programmed values move only on a load
  // R9
  property hold_without_load_p;
    @(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(a_q) && $stable(m_q) && $stable(err_q));
  endproperty
  shadow_hold_chk: assert property (hold_without_load_p);
endmodule

// File: rtl/psc_a_stage.sv
`timescale 1ns/1ps
module psc_a_stage #(
  parameter int   A_W    = 7,
  parameter logic MC_RST = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic [A_W-1:0] a_eff,
  input  logic [A_W-1:0] a_q,
  output logic           mc
);
  logic [A_W-1:0] cnt_q, cnt_d;
  logic           mc_q, mc_d;
  logic           cnt_en;
  logic [A_W:0]   cnt_inc;

  assign cnt_en  = restart || !mc_q;
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    mc_d  = mc_q;
    if (restart) begin
      cnt_d = '0;
      mc_d  = (a_eff == '0);
    end else if (!mc_q) begin
      cnt_d = cnt_inc[A_W-1:0];
      mc_d  = (cnt_inc == {1'b0, a_q});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mc_q  <= MC_RST;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      mc_q  <= mc_d;
    end
  end

  assign mc = mc_q;

  // R2: while mc is low the swallow count has not reached A
  // R2
  swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_q |-> (cnt_q < a_q));

  // R2: mc only returns low at the start of a new cycle
  // R2
  mc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mc_q) |-> $past(restart));
endmodule

// File: rtl/psc_m_stage.sv
`timescale 1ns/1ps
module psc_m_stage #(
  parameter int   M_W    = 10,
  parameter logic FV_RST = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           load,
  input  logic           cfg_err,
  input  logic [M_W-1:0] m_eff,
  input  logic [M_W-1:0] m_q,
  output logic           fv
);
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           fv_q, fv_d;
  logic [M_W:0]   cnt_ahead;

  // terminal position is M-1; flag it one clock early from cnt+2 == M
  assign cnt_ahead = {1'b0, cnt_q} + 2'd2;

  always_comb begin
    if (restart) begin
      cnt_d = '0;
      fv_d  = (m_eff == M_W'(1));
    end else begin
      cnt_d = cnt_q + 1'b1;
      fv_d  = (cnt_ahead == {1'b0, m_q});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fv_q  <= FV_RST;
    end else begin
      cnt_q <= cnt_d;
      fv_q  <= fv_d;
    end
  end

  assign fv = fv_q;

  // R3: main count stays inside the cycle for a valid program
  // R3
  main_bound_chk: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    cnt_q < m_q);

  // R3: the cycle pulse lasts a single clock
  // R3
  fv_single_chk: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    (fv_q && !load) |=> !fv_q);
endmodule

// File: rtl/pulse_swallow_ctrl.sv
`timescale 1ns/1ps
module pulse_swallow_ctrl
  import psc_pkg::*;
#(
  parameter int A_W       = 7,
  parameter int M_W       = 10,
  parameter int M_MIN     = M_FLOOR,
  parameter int DEF_A     = DEF_A_VAL,
  parameter int DEF_M     = DEF_M_VAL,
  parameter int SYNC_DEPTH = 2
) (
  input  logic           clk_fin,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [M_W-1:0] m_in,
  output logic           mc,
  output logic           fv,
  output logic           cfg_err
);
  localparam logic MC_AT_RST = (DEF_A == 0);
  localparam logic FV_AT_RST = (DEF_M == 1);

  logic           rst_i_n;
  logic [A_W-1:0] a_q, a_eff;
  logic [M_W-1:0] m_q, m_eff;
  logic           restart;

  psc_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk_fin), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  psc_shadow #(
    .A_W(A_W), .M_W(M_W), .M_MIN(M_MIN), .DEF_A(DEF_A), .DEF_M(DEF_M)
  ) u_shadow (
    .clk(clk_fin), .rst_n(rst_i_n), .load(load), .a_in(a_in), .m_in(m_in),
    .a_q(a_q), .m_q(m_q), .err_q(cfg_err)
  );

  // the loading edge already counts with the new values
  assign a_eff   = load ? a_in : a_q;
  assign m_eff   = load ? m_in : m_q;
  assign restart = load || fv;

  psc_a_stage #(.A_W(A_W), .MC_RST(MC_AT_RST)) u_a (
    .clk(clk_fin), .rst_n(rst_i_n), .restart(restart),
    .a_eff(a_eff), .a_q(a_q), .mc(mc)
  );

  psc_m_stage #(.M_W(M_W), .FV_RST(FV_AT_RST)) u_m (
    .clk(clk_fin), .rst_n(rst_i_n), .restart(restart), .load(load),
    .cfg_err(cfg_err), .m_eff(m_eff), .m_q(m_q), .fv(fv)
  );

  // R2: with M > A the swallow phase always ends before the terminal position
  // R2
  mc_at_term_chk: assert property (@(posedge clk_fin) disable iff (!rst_i_n || cfg_err)
    fv |-> mc);

  // R5: a load always opens position 0 on the next clock
  // R5
  load_restart_chk: assert property (@(posedge clk_fin) disable iff (!rst_i_n)
    (load && !pair_bad(int'(m_in), int'(a_in), M_MIN)) |=> (!fv && (mc == $past(a_in == '0))));
endmodule

// File: tb/pulse_swallow_ctrl_bench.sv
`timescale 1ns/1ps
module pulse_swallow_ctrl_bench;
  logic       clk_fin = 1'b0;
  logic       rst_n;
  logic       load;
  logic [6:0] a_in;
  logic [9:0] m_in;
  logic       mc, fv, cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  int pos    = 0;

  always #4 clk_fin = ~clk_fin;

  pulse_swallow_ctrl u_pulse_swallow_ctrl (
    .clk_fin(clk_fin), .rst_n(rst_n), .load(load), .a_in(a_in), .m_in(m_in),
    .mc(mc), .fv(fv), .cfg_err(cfg_err)
  );

  // {A, M} programs walked by the main loop
  localparam logic [16:0] VECS [0:5] = '{
    {7'd0,   10'd8},
    {7'd7,   10'd8},
    {7'd5,   10'd13},
    {7'd3,   10'd20},
    {7'd127, 10'd128},
    {7'd1,   10'd1023}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic walk(input int a, input int m, input int n, input string rq);
    for (int k = 0; k < n; k++) begin
      chk(rq, 16'(mc), 16'(pos >= a));
      chk("R3", 16'(fv), 16'(pos == m - 1));
      pos = (pos + 1) % m;
      @(negedge clk_fin);
    end
  endtask

  task automatic do_load(input int a, input int m);
    load = 1'b1;
    a_in = 7'(a);
    m_in = 10'(m);
    @(negedge clk_fin);
    load = 1'b0;
    pos  = 0;
  endtask

  initial begin
    #800000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    string rq;
    rst_n = 1'b0;
    load  = 1'b0;
    a_in  = '0;
    m_in  = '0;
    repeat (3) @(negedge clk_fin);
    // R1: reset state
    chk("R1", 16'(mc), 16'd0);
    chk("R1", 16'(fv), 16'd0);
    chk("R1", 16'(cfg_err), 16'd0);
    rst_n = 1'b1;
    @(negedge clk_fin);
    @(negedge clk_fin);
    pos = 0;
    walk(3, 16, 34, "R1");

    // R2/R3/R4/R8: table of programs, two full cycles each
    for (int v = 0; v < 6; v++) begin
      int a, m;
      a = int'(VECS[v][16:10]);
      m = int'(VECS[v][9:0]);
      do_load(a, m);
      chk("R7", 16'(cfg_err), 16'd0);
      rq = (a == 0) ? "R4" : ((a == 127 || m == 1023) ? "R8" : "R2");
      walk(a, m, 2 * m + 1, rq);
    end

    // R5: reload in the middle of a cycle
    do_load(3, 20);
    walk(3, 20, 11, "R5");
    do_load(5, 9);
    walk(5, 9, 19, "R5");
    // R5: reload exactly at the terminal position
    do_load(2, 10);
    walk(2, 10, 9, "R5");
    chk("R5", 16'(fv), 16'd1);
    do_load(6, 11);
    walk(6, 11, 23, "R5");

    // R6: load held high keeps the block at position 0
    load = 1'b1; a_in = 7'd2; m_in = 10'd9;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_fin);
      chk("R6", 16'(mc), 16'd0);
      chk("R6", 16'(fv), 16'd0);
    end
    a_in = 7'd0;
    @(negedge clk_fin);
    chk("R6", 16'(mc), 16'd1);
    chk("R6", 16'(fv), 16'd0);
    load = 1'b0;
    pos  = 0;
    walk(0, 9, 19, "R4");

    // R9: inputs ignored without load
    do_load(4, 12);
    a_in = 7'd0;
    m_in = 10'd9;
    walk(4, 12, 13, "R9");
    a_in = 7'd100;
    m_in = 10'd3;
    walk(4, 12, 13, "R9");
    chk("R9", 16'(cfg_err), 16'd0);

    // R7: configuration flag
    do_load(0, 7);
    chk("R7", 16'(cfg_err), 16'd1);
    repeat (3) @(negedge clk_fin);
    chk("R7", 16'(cfg_err), 16'd1);
    do_load(10, 10);
    chk("R7", 16'(cfg_err), 16'd1);
    do_load(9, 10);
    chk("R7", 16'(cfg_err), 16'd0);
    walk(9, 10, 21, "R2");
    do_load(0, 8);
    chk("R7", 16'(cfg_err), 16'd0);
    walk(0, 8, 9, "R4");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule